// File: doc/BRIEF.md
# Keypad Code Lock Detector

This block watches an encoded keypad and decides whether the user has keyed in the correct unlock code. It is meant for a door lock or a similar access point. The keypad front end is outside the block. It must deliver a clean, already encoded 4-bit key value in which one code means that no button is held. A button counts as pressed only on the clock edge where the key value leaves that no-button code. Holding a button, or sliding from one button to another without letting go, adds no further digit.

Two indicator outputs are driven from registers. `idle_led` is lit while the detector is waiting for the first digit. `open_led` is lit for a fixed number of clock cycles once the full code has been matched. The code digits, the code length, the no-button value and the open time are parameters. Any wrong digit drops the entry attempt, and the detector goes back to idle when the key is released. While `open_led` is lit, the keypad is not read.

Top module: `keylock_detector`

## Requirements
- R1: A synchronous active-high reset leaves `idle_led` at 1 and `open_led` at 0 after the next clock edge.
- R2: The value 4'hF on `key` means no button is held. A press is registered only on an edge where the key sampled on the previous edge was 4'hF and the current key is not, so a button held for many cycles counts as a single digit.
- R3: With the default code 16'h3A52, the digits must be entered in the order bits [3:0], [7:4], [11:8], [15:12] (2, 5, A, 3). `open_led` goes to 1 on the clock edge that samples the press of the last digit.
- R4: `open_led` stays at 1 for exactly HOLD_CYCLES clock cycles. It then returns to 0, and on the same edge `idle_led` returns to 1.
- R5: `idle_led` is 1 only while no digit of the current attempt has been taken. It goes to 0 on the edge that samples the first press.
- R6: A press of a wrong digit at any position rejects the attempt. `idle_led` stays at 0 while that key is held and returns to 1 on the edge that samples the key back at 4'hF.
- R7: While `open_led` is 1, presses have no effect. The open time is not extended, and no progress toward a new code is kept afterwards.
- R8: `idle_led` and `open_led` are never 1 at the same time.
- R9: After a rejected attempt, no digits are carried over. The full code entered afresh opens the lock.
- R10: Changing `key` from one button code straight to another, without passing through 4'hF, is not a press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key | input | KEY_W | Encoded keypad value; all ones means no button |
| idle_led | output | 1 | Lit while waiting for the first digit |
| open_led | output | 1 | Lit for HOLD_CYCLES cycles after a correct code |

## Verification
The assertions assume that `key` is already synchronous to `clk` and free of bounce. They also assume that reset is held for at least one edge before any check counts. Under these assumptions, every rise of `open_led` can be traced to a press on the edge before it. The stimulus drives `key` only on falling clock edges and always holds a button for at least one full cycle. It always returns to 4'hF between intended digits, except in the slide case, where it steps from one button code straight to another. All of these patterns stay inside that input contract.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_ENTER  = 2'd1,
    LK_REJECT = 2'd2,
    LK_OPEN   = 2'd3
  } lock_state_t;

endpackage

// File: rtl/keypad_edge.sv
module keypad_edge #(
  parameter int          KEY_W     = 4,
  parameter logic [KEY_W-1:0] NONE_CODE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  output logic             press_o,
  output logic             released_o
);

  logic [KEY_W-1:0] key_prev;

  always_ff @(posedge clk) begin
    if (rst) key_prev <= NONE_CODE;
    else     key_prev <= key;
  end

  // new button only when leaving the no-button code
  assign press_o    = (key_prev == NONE_CODE) && (key != NONE_CODE);
  assign released_o = (key == NONE_CODE);

endmodule

// File: rtl/code_digit_sel.sv
module code_digit_sel #(
  parameter int                      KEY_W    = 4,
  parameter int                      DIGITS   = 4,
  parameter logic [DIGITS*KEY_W-1:0] PASSCODE = '0,
  localparam int                     IW       = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic [IW-1:0]    idx,
  output logic [KEY_W-1:0] digit
);

  logic [KEY_W-1:0] table_q [DIGITS];

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_dig
      assign table_q[g] = PASSCODE[g*KEY_W +: KEY_W];
    end
  endgenerate

  always_comb begin
    digit = table_q[0];
    for (int i = 0; i < DIGITS; i++)
      if (idx == IW'(i)) digit = table_q[i];
  end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_CYCLES = 1000,
  localparam int TW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= TW'(HOLD_CYCLES - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/keylock_detector.sv
module keylock_detector
  import keylock_pkg::*;
#(
  parameter int                      KEY_W       = 4,
  parameter int                      DIGITS      = 4,
  parameter logic [KEY_W-1:0]        NONE_CODE   = '1,
  parameter logic [DIGITS*KEY_W-1:0] PASSCODE    = 16'h3A52,
  parameter int                      HOLD_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  output logic             idle_led,
  output logic             open_led
);

  localparam int          IW   = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [IW-1:0] LAST = IW'(DIGITS - 1);

  lock_state_t      st, st_n;
  logic [IW-1:0]    pos, pos_n;
  logic             press_w, released_w, done_w, load_w;
  logic [KEY_W-1:0] want_digit;

  keypad_edge #(.KEY_W(KEY_W), .NONE_CODE(NONE_CODE)) u_edge (
    .clk(clk), .rst(rst), .key(key),
    .press_o(press_w), .released_o(released_w)
  );

  code_digit_sel #(.KEY_W(KEY_W), .DIGITS(DIGITS), .PASSCODE(PASSCODE)) u_sel (
    .idx(pos), .digit(want_digit)
  );

  hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .load(load_w), .done(done_w)
  );

  always_comb begin
    st_n   = st;
    pos_n  = pos;
    load_w = 1'b0;
    unique case (st)
      LK_IDLE, LK_ENTER: begin
        if (press_w) begin
          if (key != want_digit) begin
            st_n  = LK_REJECT;
            pos_n = '0;
          end else if (pos == LAST) begin
            st_n   = LK_OPEN;
            pos_n  = '0;
            load_w = 1'b1;
          end else begin
            st_n  = LK_ENTER;
            pos_n = pos + 1'b1;
          end
        end
      end
      LK_REJECT: if (released_w) st_n = LK_IDLE;
      LK_OPEN:   if (done_w)     st_n = LK_IDLE;
      default:   st_n = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= LK_IDLE;
      pos      <= '0;
      idle_led <= 1'b1;
      open_led <= 1'b0;
    end else begin
      st       <= st_n;
      pos      <= pos_n;
      idle_led <= (st_n == LK_IDLE);
      open_led <= (st_n == LK_OPEN);
    end
  end

endmodule

// File: rtl/keylock_checker.sv
module keylock_checker #(
  parameter int HOLD_CYCLES = 1000
) (
  input logic clk,
  input logic rst,
  input logic press,
  input logic idle_led,
  input logic open_led
);

  int run_len;

  always_ff @(posedge clk) begin
    if (rst)           run_len <= 0;
    else if (open_led) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (idle_led && !open_led));

  assert_open_after_press_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(open_led) |-> $past(press));

  assert_open_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(open_led) |-> (run_len == HOLD_CYCLES));

  assert_back_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(open_led) |-> idle_led);

  assert_idle_left_by_press_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_led) |-> $past(press));

  assert_leds_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(idle_led && open_led));

endmodule

bind keylock_detector keylock_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .press(press_w),
  .idle_led(idle_led), .open_led(open_led)
);

// File: tb/keylock_detector_test.sv
`timescale 1ns/100ps
module keylock_detector_test;

  localparam int HOLD = 40;
  localparam logic [3:0] NB = 4'hF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] key = NB;
  logic       idle_led, open_led;

  int total = 0;
  int bad   = 0;
  int excl_err = 0;
  bit finished = 0;

  keylock_detector #(.PASSCODE(16'h3A52), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .key(key), .idle_led(idle_led), .open_led(open_led)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk)
    if (!rst && idle_led && open_led) excl_err++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tap(input logic [3:0] c, input int hold);
    @(negedge clk) key = c;
    repeat (hold) @(negedge clk);
    key = NB;
    @(negedge clk);
  endtask

  // final digit: returns number of cycles open_led was seen high
  task automatic finish_code(input logic [3:0] c, output int n);
    @(negedge clk) key = c;
    @(negedge clk);
    n = 0;
    key = NB;
    while (open_led && n < 10*HOLD) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    key = NB;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(idle_led == 1'b1, "R1", "idle_led after reset", idle_led, 1);
    check(open_led == 1'b0, "R1", "open_led after reset", open_led, 0);
  endtask

  task automatic t_good;
    int n;
    @(negedge clk) key = 4'h2;
    @(negedge clk);
    check(idle_led == 1'b0, "R5", "idle_led after first press", idle_led, 1'b0);
    key = NB;
    @(negedge clk);
    tap(4'h5, 2);
    tap(4'hA, 1);
    finish_code(4'h3, n);
    check(n == HOLD, "R3", "open pulse seen (R4 length)", n, HOLD);
    check(idle_led == 1'b1, "R4", "idle_led after open time", idle_led, 1);
    check(open_led == 1'b0, "R4", "open_led after open time", open_led, 0);
  endtask

  task automatic t_wrong;
    tap(4'h2, 1);
    @(negedge clk) key = 4'h7;
    repeat (3) @(negedge clk);
    check(idle_led == 1'b0, "R6", "idle_led while wrong key held", idle_led, 0);
    key = NB;
    @(negedge clk);
    check(idle_led == 1'b1, "R6", "idle_led after release", idle_led, 1);
    check(open_led == 1'b0, "R6", "open_led after wrong digit", open_led, 0);
  endtask

  task automatic t_retry;
    int n;
    tap(4'h2, 1);
    tap(4'h5, 1);
    tap(4'h9, 1);
    check(idle_led == 1'b1, "R9", "idle after rejected attempt", idle_led, 1);
    tap(4'h2, 1);
    tap(4'h5, 1);
    tap(4'hA, 1);
    finish_code(4'h3, n);
    check(n == HOLD, "R9", "full code after reject opens", n, HOLD);
  endtask

  task automatic t_long_hold;
    int n;
    tap(4'h2, 15);
    tap(4'h5, 1);
    tap(4'hA, 1);
    finish_code(4'h3, n);
    check(n == HOLD, "R2", "long hold counts as one digit", n, HOLD);
  endtask

  task automatic t_slide;
    int n;
    @(negedge clk) key = 4'h2;
    @(negedge clk) key = 4'h5;
    repeat (2) @(negedge clk);
    key = NB;
    @(negedge clk);
    check(idle_led == 1'b0, "R10", "slide not a wrong digit", idle_led, 0);
    tap(4'h5, 1);
    tap(4'hA, 1);
    finish_code(4'h3, n);
    check(n == HOLD, "R10", "slide ignored, code opens", n, HOLD);
  endtask

  task automatic t_ignore;
    int n;
    tap(4'h2, 1);
    tap(4'h5, 1);
    tap(4'hA, 1);
    @(negedge clk) key = 4'h3;
    @(negedge clk) key = NB;
    n = 1;
    // key in all digits plus junk while open
    for (int i = 0; i < 4; i++) begin
      logic [3:0] d;
      d = (i == 0) ? 4'h2 : (i == 1) ? 4'h5 : (i == 2) ? 4'hA : 4'h3;
      @(negedge clk) key = d;
      if (open_led) n++;
      @(negedge clk) key = NB;
      if (open_led) n++;
    end
    while (open_led && n < 10*HOLD) begin
      @(negedge clk);
      if (open_led) n++;
    end
    check(n == HOLD, "R7", "open time not extended", n, HOLD);
    check(idle_led == 1'b1, "R7", "idle after open time", idle_led, 1);
    tap(4'h5, 1);
    tap(4'hA, 1);
    @(negedge clk) key = 4'h3;
    @(negedge clk);
    check(open_led == 1'b0, "R7", "no progress kept from open time", open_led, 0);
    key = NB;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_good();
    t_wrong();
    t_retry();
    t_long_hold();
    t_slide();
    t_ignore();
    check(excl_err == 0, "R8", "cycles with both LEDs lit", excl_err, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule